// File: doc/BRIEF.md
# Slot-Specific I/O Address-Enable Generator

This block sits in the system-board bus controller of an expansion bus that carries both older ten-bit-decode cards and newer slot-addressed cards. For every bus cycle it decides which expansion slots may decode the address. It drives one active-high enable per slot and one board-select line for the system board's own I/O space.

Memory cycles and DMA transfers never enable any slot. I/O cycles are split by address bits [9:8]. A non-zero value there marks a legacy port access, and the enable is broadcast to every slot. A zero value marks a slot-addressed access. In that case address bits [15:12] name the target slot: 0 means the system board, and 1 to NSLOTS mean expansion slots.

The outputs are registered. They reflect the cycle that was presented at the previous clock edge.

Top module: `slot_aen_gen`

## Requirements
- R1: A synchronous active-high reset clears every slot enable and the board-select output on the next clock edge.
- R2: When a valid cycle has `io_cycle` low (memory space), the next edge leaves all slot enables and board-select low.
- R3: When `dma_busy` is high, the next edge leaves all slot enables and board-select low, even for a valid I/O cycle.
- R4: A valid I/O cycle with no DMA and address bits [9:8] not equal to 00 sets every bit of `slot_en` and clears `board_sel` on the next edge.
- R5: In the broadcast case of R4, the result does not depend on address bits above bit 9.
- R6: A valid I/O cycle with no DMA, bits [9:8] = 00 and bits [15:12] = n with 1 <= n <= NSLOTS sets only `slot_en[n-1]` on the next edge. Bit i of `slot_en` belongs to slot i+1, and `board_sel` stays low.
- R7: A valid I/O cycle with no DMA, bits [9:8] = 00 and bits [15:12] = 0 sets `board_sel` and no slot enable. `board_sel` is never high together with any slot enable.
- R8: A valid slot-addressed I/O cycle whose slot number in bits [15:12] exceeds NSLOTS asserts no slot enable and no board-select.
- R9: While `cyc_valid` is low, the next edge drives all slot enables and board-select low. The outputs therefore clear in the cycle after the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Current bus address |
| io_cycle | input | 1 | 1 = I/O-space cycle, 0 = memory-space cycle |
| cyc_valid | input | 1 | Cycle-valid strobe |
| dma_busy | input | 1 | DMA transfer in progress |
| slot_en | output | NSLOTS | Per-slot address enable; bit i serves slot i+1 |
| board_sel | output | 1 | System-board I/O select |

## Verification
The assertions take for granted that all inputs hold known, non-X values at every rising edge after reset. They also assume that NSLOTS lies between 1 and 15, so every enabled slot has a four-bit number.

The bench changes every input only at the falling clock edge and always drives defined levels. It samples the outputs one time unit after the rising edge that registers them. Between scenarios it drops the strobe for one cycle, so that the clear-after-strobe behaviour is also observed each time.

// File: rtl/slot_aen_pkg.sv
package slot_aen_pkg;

    // Classification of the cycle presented on the bus
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_BCAST = 2'd1,
        KIND_SLOT  = 2'd2,
        KIND_BOARD = 2'd3
    } cyc_kind_e;

    localparam int unsigned SLOT_NUM_W = 4;
    localparam int unsigned SLOT_LSB   = 12;
    localparam int unsigned SEL_LSB    = 8;

endpackage

// File: rtl/slot_aen_classify.sv
module slot_aen_classify
    import slot_aen_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  io_i,
    input  logic                  valid_i,
    input  logic                  dma_i,
    output cyc_kind_e             kind_o,
    output logic [SLOT_NUM_W-1:0] slot_o
);

    logic       qualified;
    logic [1:0] sel_bits;

    assign sel_bits  = addr_i[SEL_LSB+1:SEL_LSB];
    assign qualified = valid_i & io_i & ~dma_i;
    assign slot_o    = addr_i[SLOT_LSB+SLOT_NUM_W-1:SLOT_LSB];

    always_comb begin
        kind_o = KIND_NONE;
        if (qualified) begin
            if (sel_bits != 2'b00) begin
                kind_o = KIND_BCAST;
            end else if (slot_o == '0) begin
                kind_o = KIND_BOARD;
            end else begin
                kind_o = KIND_SLOT;
            end
        end
    end

endmodule

// File: rtl/slot_aen_expand.sv
module slot_aen_expand
    import slot_aen_pkg::*;
#(
    parameter int unsigned NSLOTS = 8
) (
    input  cyc_kind_e             kind_i,
    input  logic [SLOT_NUM_W-1:0] slot_i,
    output logic [NSLOTS-1:0]     en_o
);

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        localparam logic [SLOT_NUM_W-1:0] MY_NUM = SLOT_NUM_W'(g + 1);
        assign en_o[g] = (kind_i == KIND_BCAST) ||
                         ((kind_i == KIND_SLOT) && (slot_i == MY_NUM));
    end

endmodule

// File: rtl/slot_aen_gen.sv
module slot_aen_gen
    import slot_aen_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NSLOTS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              io_cycle,
    input  logic              cyc_valid,
    input  logic              dma_busy,
    output logic [NSLOTS-1:0] slot_en,
    output logic              board_sel
);

    localparam int unsigned MAX_SLOTS = (1 << SLOT_NUM_W) - 1;

    typedef struct packed {
        logic [NSLOTS-1:0] en;
        logic              board;
    } aen_state_t;

    cyc_kind_e             kind;
    logic [SLOT_NUM_W-1:0] slot_num;
    logic [NSLOTS-1:0]     en_vec;
    aen_state_t            state_d;
    aen_state_t            state_q;

    initial begin
        if (NSLOTS < 1 || NSLOTS > MAX_SLOTS) begin
            $error("slot_aen_gen: NSLOTS out of range");
        end
    end

    slot_aen_classify #(
        .ADDR_W (ADDR_W)
    ) u_classify (
        .addr_i  (bus_addr),
        .io_i    (io_cycle),
        .valid_i (cyc_valid),
        .dma_i   (dma_busy),
        .kind_o  (kind),
        .slot_o  (slot_num)
    );

    slot_aen_expand #(
        .NSLOTS (NSLOTS)
    ) u_expand (
        .kind_i (kind),
        .slot_i (slot_num),
        .en_o   (en_vec)
    );

    always_comb begin
        state_d.en    = en_vec;
        state_d.board = (kind == KIND_BOARD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign slot_en   = state_q.en;
    assign board_sel = state_q.board;

endmodule

// File: rtl/slot_aen_gen_chk.sv
module slot_aen_gen_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned NSLOTS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              io_cycle,
    input logic              cyc_valid,
    input logic              dma_busy,
    input logic [NSLOTS-1:0] slot_en,
    input logic              board_sel
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (slot_en == '0) && !board_sel);

    // R2
    mem_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !io_cycle) |=> (slot_en == '0) && !board_sel);

    // R3
    dma_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dma_busy |=> (slot_en == '0) && !board_sel);

    // R4
    bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && io_cycle && !dma_busy && (bus_addr[9:8] != 2'b00))
        |=> (&slot_en) && !board_sel);

    // R6
    slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && io_cycle && !dma_busy && (bus_addr[9:8] == 2'b00))
        |=> $onehot0({slot_en, board_sel}));

    // R7
    board_excl_chk: assert property (@(posedge clk) disable iff (rst)
        board_sel |-> (slot_en == '0));

    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> (slot_en == '0) && !board_sel);

endmodule

bind slot_aen_gen slot_aen_gen_chk #(
    .ADDR_W (ADDR_W),
    .NSLOTS (NSLOTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .io_cycle  (io_cycle),
    .cyc_valid (cyc_valid),
    .dma_busy  (dma_busy),
    .slot_en   (slot_en),
    .board_sel (board_sel)
);

// File: tb/slot_aen_gen_tb.sv
`timescale 1ns/1ps
module slot_aen_gen_tb;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned NSLOTS = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              io_cycle = 1'b0;
    logic              cyc_valid = 1'b0;
    logic              dma_busy = 1'b0;
    logic [NSLOTS-1:0] slot_en;
    logic              board_sel;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;

    slot_aen_gen #(
        .ADDR_W (ADDR_W),
        .NSLOTS (NSLOTS)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .io_cycle  (io_cycle),
        .cyc_valid (cyc_valid),
        .dma_busy  (dma_busy),
        .slot_en   (slot_en),
        .board_sel (board_sel)
    );

    task automatic check(input string req, input logic [NSLOTS-1:0] exp_en,
                         input logic exp_board);
        n_cmp++;
        if (slot_en !== exp_en || board_sel !== exp_board) begin
            n_bad++;
            $display("FAIL %s: got en=%b board=%b, expected en=%b board=%b",
                     req, slot_en, board_sel, exp_en, exp_board);
        end
    endtask

    // Present one cycle and sample after the registering edge
    task automatic present(input logic [ADDR_W-1:0] a, input logic io,
                           input logic dma);
        @(negedge clk);
        bus_addr  = a;
        io_cycle  = io;
        dma_busy  = dma;
        cyc_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic drop_strobe(input string req);
        @(negedge clk);
        cyc_valid = 1'b0;
        dma_busy  = 1'b0;
        @(posedge clk);
        #1;
        check(req, '0, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", '0, 1'b0);
        present(16'h3000, 1'b1, 1'b0);
        check("R1 held in reset", '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        cyc_valid = 1'b0;
    endtask

    task automatic t_reset_mid;
        present(16'h0300, 1'b1, 1'b0);
        check("R1 pre", '1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        cyc_valid = 1'b0;
    endtask

    task automatic t_memory;
        present(16'h2000, 1'b0, 1'b0);
        check("R2 memory slot-coded", '0, 1'b0);
        present(16'h0100, 1'b0, 1'b0);
        check("R2 memory bcast-coded", '0, 1'b0);
        drop_strobe("R9");
    endtask

    task automatic t_dma;
        present(16'h0200, 1'b1, 1'b1);
        check("R3 dma bcast", '0, 1'b0);
        present(16'h3000, 1'b1, 1'b1);
        check("R3 dma slot", '0, 1'b0);
        present(16'h0000, 1'b1, 1'b1);
        check("R3 dma board", '0, 1'b0);
        drop_strobe("R9");
    endtask

    task automatic t_bcast;
        present(16'h0100, 1'b1, 1'b0);
        check("R4 bits 01", '1, 1'b0);
        present(16'h0278, 1'b1, 1'b0);
        check("R4 bits 10", '1, 1'b0);
        present(16'h03F8, 1'b1, 1'b0);
        check("R4 bits 11", '1, 1'b0);
        drop_strobe("R9");
    endtask

    task automatic t_bcast_high;
        for (int h = 0; h < 64; h += 7) begin
            present({6'(h), 10'h1F0}, 1'b1, 1'b0);
            check("R5 high bits ignored", '1, 1'b0);
        end
        present(16'hF300, 1'b1, 1'b0);
        check("R5 slot-like high bits", '1, 1'b0);
        drop_strobe("R9");
    endtask

    task automatic t_slots;
        for (int n = 1; n <= NSLOTS; n++) begin
            logic [NSLOTS-1:0] e;
            e = '0;
            e[n-1] = 1'b1;
            present({4'(n), 12'h0C8}, 1'b1, 1'b0);
            check($sformatf("R6 slot %0d", n), e, 1'b0);
        end
        drop_strobe("R9");
    endtask

    task automatic t_board;
        present(16'h0000, 1'b1, 1'b0);
        check("R7 board", '0, 1'b1);
        present(16'h00C4, 1'b1, 1'b0);
        check("R7 board low bits", '0, 1'b1);
        present(16'h5000, 1'b1, 1'b0);
        check("R7 board to slot", 8'b0001_0000, 1'b0);
        drop_strobe("R9");
    endtask

    task automatic t_beyond;
        for (int n = NSLOTS + 1; n < 16; n++) begin
            present({4'(n), 12'h000}, 1'b1, 1'b0);
            check($sformatf("R8 slot %0d", n), '0, 1'b0);
        end
        drop_strobe("R9");
    endtask

    task automatic t_strobe;
        present(16'h1000, 1'b1, 1'b0);
        check("R9 pre", 8'b0000_0001, 1'b0);
        @(negedge clk);
        cyc_valid = 1'b0;
        bus_addr  = 16'h0300;
        #1;
        check("R9 held until edge", 8'b0000_0001, 1'b0);
        @(posedge clk);
        #1;
        check("R9 clear after strobe", '0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_memory();
        t_dma();
        t_bcast();
        t_bcast_high();
        t_slots();
        t_board();
        t_beyond();
        t_strobe();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule